// File: doc/BRIEF.md
# Infrared Remote Packet Transmitter

This block drives the infrared LED of a remote control for a toy vehicle. Ten times per second it sends one packet. A packet is a fixed run of six bursts, each followed by a dark gap. The bursts are, in order, a start burst, a vehicle-select burst, and one burst for each direction: right, left, forward, backward. During a burst the LED is switched on and off at the 36 kHz carrier rate. During a gap the LED is held off.

A direction burst tells the receiver whether its button is held. The burst is long when the button is held and short when it is not. All lengths are parameters counted in whole carrier periods. The carrier period and the frame period are parameters counted in system clocks. The defaults are 2778 and 10,000,000 clocks, which give 36 kHz and 10 Hz from a 100 MHz clock.

Everything runs in one clock domain. A free-running carrier timer and a free-running frame timer each produce a one-cycle enable. A frame enable arms the sequencer. The packet then begins at the next carrier-period boundary. The four buttons are captured at that moment and held until the packet ends.

Top module: `ir_packet_tx`

## Requirements
- R1: While `rst_n` is low the LED is off. After `rst_n` rises, the LED stays off until the first frame period has elapsed.
- R2: Packets start exactly `FRAME_CLKS` clocks apart when `FRAME_CLKS` is a multiple of `CARRIER_CLKS`. The parameters must keep a full packet shorter than one frame.
- R3: A packet opens with a start burst of `START_LEN` carrier periods. After the gap that follows it comes a select burst of `SELECT_LEN` carrier periods.
- R4: Each of the six bursts is followed by a gap of `GAP_LEN` carrier periods in which the LED is held off. This includes the last burst.
- R5: Within a burst, every carrier period has the LED on for `CARRIER_CLKS/2` clocks and then off for the rest of the period. The LED is never on for longer than that at a stretch, and fields change only on carrier-period boundaries.
- R6: The four direction bursts come in the order right, left, forward, backward. Each lasts `ASSERT_LEN` carrier periods if its button is held (input high) and `DEASSERT_LEN` carrier periods if it is not.
- R7: The buttons are captured when a packet starts. A change on a button input during a packet does not change any burst length of that packet.
- R8: After the last gap the LED stays off until the next packet. A frame enable that arrives while a packet is being sent does not restart or re-arm the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_right | input | 1 | Right button, high when held |
| btn_left | input | 1 | Left button, high when held |
| btn_fwd | input | 1 | Forward button, high when held |
| btn_back | input | 1 | Backward button, high when held |
| ir_led | output | 1 | Modulated LED drive, high means LED on |

## Verification
Several properties are checked on every cycle:
- the LED is dark during gaps and in idle;
- a run of LED-on clocks is never longer than half a carrier period;
- fields change only right after a carrier enable;
- the captured buttons do not move during a packet;
- a frame enable during a packet never re-arms the sequencer.

The exact burst and gap lengths for a given button pattern can only be shown by the bench scenarios. The same holds for the field order, the spacing between packets, and the insensitivity to button changes made in mid-packet. The bench compares the LED clock by clock against a waveform built from the requirements. Recovery from a reset that lands in the middle of a packet is also shown only by a bench scenario.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int unsigned FIELD_CNT = 12;
  localparam int unsigned IDX_W     = 4;

  typedef logic [IDX_W-1:0] field_idx_t;

  localparam field_idx_t LAST_IDX = field_idx_t'(FIELD_CNT - 1);

  // IDLE: waiting for frame enable; ARMED: waiting for carrier boundary
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARMED = 2'd1,
    SQ_SEND  = 2'd2
  } seq_state_e;

  // burst kind = field index / 2 (odd indices are gaps)
  typedef enum logic [2:0] {
    BK_START  = 3'd0,
    BK_SELECT = 3'd1,
    BK_RIGHT  = 3'd2,
    BK_LEFT   = 3'd3,
    BK_FWD    = 3'd4,
    BK_BACK   = 3'd5
  } burst_kind_e;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irtx_tick.sv
module irtx_tick #(
  parameter int unsigned PERIOD = 2778
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb,
  output logic hi
);
  localparam int unsigned CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF = CW'(PERIOD / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stb = (cnt_q == LAST);
  assign hi  = (cnt_q < HALF);

  generate
    if (PERIOD > 1) begin : g_chk
      AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) stb |=> !stb); // R2
    end
  endgenerate
endmodule

// File: rtl/irtx_field_len.sv
module irtx_field_len
  import irtx_pkg::*;
#(
  parameter int unsigned START_LEN    = 96,
  parameter int unsigned SELECT_LEN   = 48,
  parameter int unsigned GAP_LEN      = 24,
  parameter int unsigned ASSERT_LEN   = 48,
  parameter int unsigned DEASSERT_LEN = 24,
  parameter int unsigned LEN_W        = 8
) (
  input  field_idx_t       idx,
  input  logic [3:0]       btn,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] L_START = LEN_W'(START_LEN);
  localparam logic [LEN_W-1:0] L_SEL   = LEN_W'(SELECT_LEN);
  localparam logic [LEN_W-1:0] L_GAP   = LEN_W'(GAP_LEN);
  localparam logic [LEN_W-1:0] L_ON    = LEN_W'(ASSERT_LEN);
  localparam logic [LEN_W-1:0] L_OFF   = LEN_W'(DEASSERT_LEN);

  burst_kind_e kind;

  always_comb begin
    kind = burst_kind_e'(idx[3:1]);
    if (idx[0]) begin
      len = L_GAP;
    end else begin
      case (kind)
        BK_START:  len = L_START;
        BK_SELECT: len = L_SEL;
        BK_RIGHT:  len = btn[0] ? L_ON : L_OFF;
        BK_LEFT:   len = btn[1] ? L_ON : L_OFF;
        BK_FWD:    len = btn[2] ? L_ON : L_OFF;
        BK_BACK:   len = btn[3] ? L_ON : L_OFF;
        default:   len = L_GAP;
      endcase
    end
  end
endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
  import irtx_pkg::*;
#(
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned HALF_CLKS = 1389
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic             car_stb,
  input  logic             car_hi,
  input  logic [3:0]       btn_in,
  input  logic [LEN_W-1:0] cur_len,
  output field_idx_t       idx_o,
  output logic [3:0]       btn_o,
  output logic             led_o
);
  seq_state_e       state_q, state_d;
  field_idx_t       idx_q, idx_d;
  logic [LEN_W-1:0] fcnt_q, fcnt_d;
  logic [3:0]       btn_q, btn_d;
  logic             led_q, led_d;
  logic             last_beat;

  // next-state process
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    fcnt_d    = fcnt_q;
    btn_d     = btn_q;
    last_beat = (fcnt_q == (cur_len - 1'b1));
    case (state_q)
      SQ_IDLE: begin
        if (frame_stb) state_d = SQ_ARMED;
      end
      SQ_ARMED: begin
        if (car_stb) begin
          state_d = SQ_SEND;
          idx_d   = '0;
          fcnt_d  = '0;
          btn_d   = btn_in;
        end
      end
      SQ_SEND: begin
        if (car_stb) begin
          if (last_beat) begin
            fcnt_d = '0;
            if (idx_q == LAST_IDX) begin
              state_d = SQ_IDLE;
              idx_d   = '0;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            fcnt_d = fcnt_q + 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
    led_d = (state_q == SQ_SEND) && !idx_q[0] && car_hi;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      fcnt_q  <= '0;
      btn_q   <= '0;
      led_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      fcnt_q  <= fcnt_d;
      btn_q   <= btn_d;
      led_q   <= led_d;
    end
  end

  assign idx_o = idx_q;
  assign btn_o = btn_q;
  assign led_o = led_q;

  // run length of LED-on clocks, kept for the carrier check
  logic [15:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hi_run_q <= '0;
    else if (!led_q)              hi_run_q <= '0;
    else if (hi_run_q != 16'hFFFF) hi_run_q <= hi_run_q + 1'b1;
  end

  AST_LED_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    led_q |-> (hi_run_q < 16'(HALF_CLKS))); // R5
  AST_FIELD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SEND && $past(state_q == SQ_SEND) && idx_q != $past(idx_q)) |-> $past(car_stb)); // R5
  AST_GAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SEND && idx_q[0] && $past(state_q == SQ_SEND && idx_q[0])) |-> !led_q); // R4
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && $past(state_q == SQ_IDLE)) |-> !led_q); // R8
  AST_BTN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SEND && $past(state_q == SQ_SEND)) |-> $stable(btn_q)); // R7
  AST_FRAME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SEND && frame_stb) |=> (state_q != SQ_ARMED)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX); // R3
endmodule

// File: rtl/ir_packet_tx.sv
module ir_packet_tx
  import irtx_pkg::*;
#(
  parameter int unsigned CARRIER_CLKS = 2778,
  parameter int unsigned FRAME_CLKS   = 10_000_000,
  parameter int unsigned START_LEN    = 96,
  parameter int unsigned SELECT_LEN   = 48,
  parameter int unsigned GAP_LEN      = 24,
  parameter int unsigned ASSERT_LEN   = 48,
  parameter int unsigned DEASSERT_LEN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_right,
  input  logic btn_left,
  input  logic btn_fwd,
  input  logic btn_back,
  output logic ir_led
);
  localparam int unsigned DIR_MAX = umax(ASSERT_LEN, DEASSERT_LEN);
  localparam int unsigned MAX_LEN = umax(umax(START_LEN, SELECT_LEN), umax(GAP_LEN, DIR_MAX));
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);
  localparam longint unsigned PKT_CLKS =
    longint'(START_LEN + SELECT_LEN + 4 * DIR_MAX + 6 * GAP_LEN) * longint'(CARRIER_CLKS);

  // parameter sanity: a packet plus arming delay must fit in one frame
  initial begin
    AST_PKT_FITS: assert (PKT_CLKS + 2 * CARRIER_CLKS < longint'(FRAME_CLKS))
      else $error("packet longer than frame period"); // R2
  end

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             car_stb, car_hi;
  logic             frm_stb, frm_hi_unused;
  field_idx_t       idx;
  logic [3:0]       btn_lat;
  logic [LEN_W-1:0] cur_len;
  logic             led;

  irtx_tick #(.PERIOD(CARRIER_CLKS)) u_carrier (
    .clk(clk), .rst_n(rst_int_n), .stb(car_stb), .hi(car_hi)
  );

  irtx_tick #(.PERIOD(FRAME_CLKS)) u_frame (
    .clk(clk), .rst_n(rst_int_n), .stb(frm_stb), .hi(frm_hi_unused)
  );

  irtx_field_len #(
    .START_LEN(START_LEN), .SELECT_LEN(SELECT_LEN), .GAP_LEN(GAP_LEN),
    .ASSERT_LEN(ASSERT_LEN), .DEASSERT_LEN(DEASSERT_LEN), .LEN_W(LEN_W)
  ) u_len (
    .idx(idx), .btn(btn_lat), .len(cur_len)
  );

  irtx_seq #(.LEN_W(LEN_W), .HALF_CLKS(CARRIER_CLKS / 2)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .frame_stb(frm_stb), .car_stb(car_stb), .car_hi(car_hi),
    .btn_in({btn_back, btn_fwd, btn_left, btn_right}),
    .cur_len(cur_len), .idx_o(idx), .btn_o(btn_lat), .led_o(led)
  );

  assign ir_led = led;

  AST_RESET_DARK: assert property (@(posedge clk) !rst_int_n |-> !ir_led); // R1
endmodule

// File: tb/ir_packet_tx_bench.sv
module ir_packet_tx_bench;
  localparam int CAR   = 8;
  localparam int HALF  = CAR / 2;
  localparam int FRAME = 1000;
  localparam int L_ST  = 4;
  localparam int L_SEL = 3;
  localparam int L_GAP = 2;
  localparam int L_ON  = 5;
  localparam int L_OFF = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] btns = 4'b0000;   // bit0 right, bit1 left, bit2 forward, bit3 backward
  logic       ir_led;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int last_start = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ir_packet_tx #(
    .CARRIER_CLKS(CAR), .FRAME_CLKS(FRAME), .START_LEN(L_ST), .SELECT_LEN(L_SEL),
    .GAP_LEN(L_GAP), .ASSERT_LEN(L_ON), .DEASSERT_LEN(L_OFF)
  ) u_ir_packet_tx (
    .clk(clk), .rst_n(rst_n),
    .btn_right(btns[0]), .btn_left(btns[1]), .btn_fwd(btns[2]), .btn_back(btns[3]),
    .ir_led(ir_led)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise(output bit found);
    found = 1'b0;
    for (int i = 0; i < 2 * FRAME; i++) begin
      if (ir_led === 1'b1) begin
        found = 1'b1;
        last_start = cyc;
        return;
      end
      @(negedge clk);
    end
  endtask

  // expected LED waveform of one packet, compared clock by clock
  task automatic check_packet(input logic [3:0] b, input bit flip);
    bit found;
    wait_rise(found);
    chk(found, "R2 packet start", int'(found), 1);
    if (!found) return;
    for (int f = 0; f < 12; f++) begin
      int len;
      int bad;
      bit burst;
      burst = (f % 2 == 0);
      if (!burst)      len = L_GAP;
      else if (f == 0) len = L_ST;
      else if (f == 2) len = L_SEL;
      else             len = b[f/2 - 2] ? L_ON : L_OFF;
      bad = 0;
      for (int j = 0; j < len * CAR; j++) begin
        logic e;
        e = burst && ((j % CAR) < HALF);
        if (ir_led !== e) bad++;
        if (flip && f == 0 && j == 3) btns = ~b;
        @(negedge clk);
      end
      if (!burst)
        chk(bad == 0, $sformatf("R4 gap field %0d mismatches", f), bad, 0);
      else if (f < 4)
        chk(bad == 0, $sformatf("R3 R5 burst field %0d mismatches", f), bad, 0);
      else if (flip)
        chk(bad == 0, $sformatf("R7 direction field %0d mismatches", f), bad, 0);
      else
        chk(bad == 0, $sformatf("R6 R5 direction field %0d mismatches", f), bad, 0);
    end
    begin
      int highs = 0;
      for (int k = 0; k < 100; k++) begin
        if (ir_led !== 1'b0) highs++;
        @(negedge clk);
      end
      chk(highs == 0, "R8 dark after packet", highs, 0);
    end
  endtask

  task automatic t_reset_initial();
    int highs = 0;
    rst_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (ir_led !== 1'b0) highs++;
    end
    chk(highs == 0, "R1 LED off in reset", highs, 0);
    rst_n = 1'b1;
    highs = 0;
    for (int k = 0; k < 900; k++) begin
      @(negedge clk);
      if (ir_led !== 1'b0) highs++;
    end
    chk(highs == 0, "R1 LED off before first frame", highs, 0);
  endtask

  task automatic t_packet(input logic [3:0] b, input bit flip);
    btns = b;
    check_packet(b, flip);
  endtask

  task automatic t_period();
    int s1;
    btns = 4'b1010;
    check_packet(4'b1010, 1'b0);
    s1 = last_start;
    check_packet(4'b1010, 1'b0);
    chk(last_start - s1 == FRAME, "R2 packet spacing", last_start - s1, FRAME);
  endtask

  task automatic t_reset_mid();
    bit found;
    int highs = 0;
    btns = 4'b0011;
    wait_rise(found);
    chk(found, "R1 packet before mid reset", int'(found), 1);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (ir_led !== 1'b0) highs++;
    end
    chk(highs == 0, "R1 LED off during mid-packet reset", highs, 0);
    rst_n = 1'b1;
    highs = 0;
    for (int k = 0; k < 900; k++) begin
      @(negedge clk);
      if (ir_led !== 1'b0) highs++;
    end
    chk(highs == 0, "R1 LED off after reset release", highs, 0);
    check_packet(4'b0011, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset_initial();
    t_packet(4'b0000, 1'b0);
    t_packet(4'b1111, 1'b0);
    t_packet(4'b0101, 1'b1);
    t_period();
    t_reset_mid();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule